// File: doc/BRIEF.md
# Block Memory Transfer Engine

This engine copies a programmed number of bytes from one place in a 64 KiB byte space to another. One start pulse supplies the pattern code, the source address, the destination address, the length and a stack pointer with three register values. The engine first writes the three register values below the stack pointer through a separate stack write port. It then moves the bytes one at a time over a simple memory port. Each byte takes six cycles: a read, one cycle to capture the returned data, three idle cycles, and a write.

Five address patterns are offered. Both addresses can count up, or both can count down. The source can count up while the destination stays fixed. In the two swinging patterns, one side alternates between +1 and −1 after every byte, starting with +1. In the first of these the source counts up and the destination swings. In the second the source swings and the destination counts up. Addresses wrap modulo 65536. A length of zero means 65536 bytes. The engine reports busy while working and gives a one-cycle done pulse when the last write has completed.

Top module: `bmx_engine`

## Requirements
- R1: After reset, and after any reset applied in the middle of a transfer, `busy_o`, `done_o`, `mem_re_o`, `mem_we_o` and `stk_we_o` are all 0.
- R2: When a start is accepted, the three cycles that follow carry one stack write each, in this order: the Y value at offset sp−1, the A value at sp−2, then the X value at sp−3. The offsets are 8-bit and wrap, so sp=0x01 gives 0x00, 0xFF and 0xFE.
- R3: Each byte takes six cycles. The first is a read strobe to the source address. `mem_rdata_i` is sampled one cycle later. Five cycles after the read, a write strobe to the destination address carries that data. The first read comes in the cycle right after the third stack write, and no two strobes are ever active in the same cycle.
- R4: Pattern code 0: the source and the destination both step +1 after each byte.
- R5: Pattern code 1: the source and the destination both step −1 after each byte.
- R6: Pattern code 2: the source steps +1 and the destination stays fixed.
- R7: Pattern code 3: the source steps +1 and the destination steps +1, −1, +1, … in turn.
- R8: Pattern code 4: the source steps +1, −1, +1, … in turn and the destination steps +1.
- R9: Both addresses wrap modulo 65536 in both directions.
- R10: A length of 0 moves 65536 bytes. A length of N from 1 to 65535 moves N bytes.
- R11: `busy_o` is high from the cycle after the accepting edge through the cycle of the final write. `done_o` is high for exactly the one cycle that follows the final write, and in that same cycle `busy_o` is low.
- R12: A start request while `busy_o` is high is ignored. The running transfer keeps its addresses, pattern and length.
- R13: The unused pattern codes 5, 6 and 7 behave like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| mode_i | input | 3 | Address pattern code |
| src_i | input | 16 | First source address |
| dst_i | input | 16 | First destination address |
| len_i | input | 16 | Byte count, 0 meaning 65536 |
| sp_i | input | 8 | Stack pointer for the three saves |
| reg_y_i | input | 8 | Value saved first (at sp−1) |
| reg_a_i | input | 8 | Value saved second (at sp−2) |
| reg_x_i | input | 8 | Value saved third (at sp−3) |
| stk_we_o | output | 1 | Stack write strobe |
| stk_addr_o | output | 8 | Stack write offset |
| stk_wdata_o | output | 8 | Stack write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory address for the active strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Count cycles from the rising edge that accepts a start. The stack writes fall in cycles 1, 2 and 3. The read for byte b falls in cycle 4+6b and its write in cycle 9+6b. The done pulse comes one cycle after the last write. The bench's memory model returns read data on the edge after the read strobe, so that data must appear on the write five cycles later. The bench steps one falling edge at a time from the accepting edge and checks each strobe, address and data value in exactly the cycle the schedule gives it. A late or early event therefore fails its check instead of being waited for.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    // Per-side address stepping behaviour
    typedef enum logic [1:0] {
        STEP_INC   = 2'd0,
        STEP_DEC   = 2'd1,
        STEP_HOLD  = 2'd2,
        STEP_SWING = 2'd3
    } step_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PUSH = 2'd1,
        PH_MOVE = 2'd2
    } phase_e;

    // Pattern codes on mode_i
    localparam logic [2:0] PAT_UP_UP    = 3'd0;
    localparam logic [2:0] PAT_DN_DN    = 3'd1;
    localparam logic [2:0] PAT_UP_HOLD  = 3'd2;
    localparam logic [2:0] PAT_UP_SWING = 3'd3;
    localparam logic [2:0] PAT_SWING_UP = 3'd4;

endpackage

// File: rtl/bmx_mode_map.sv
module bmx_mode_map
    import bmx_pkg::*;
(
    input  logic [2:0] mode_i,
    output step_e      src_step_o,
    output step_e      dst_step_o
);

    always_comb begin
        unique case (mode_i)
            PAT_DN_DN: begin
                src_step_o = STEP_DEC;
                dst_step_o = STEP_DEC;
            end
            PAT_UP_HOLD: begin
                src_step_o = STEP_INC;
                dst_step_o = STEP_HOLD;
            end
            PAT_UP_SWING: begin
                src_step_o = STEP_INC;
                dst_step_o = STEP_SWING;
            end
            PAT_SWING_UP: begin
                src_step_o = STEP_SWING;
                dst_step_o = STEP_INC;
            end
            default: begin // code 0 and unused codes
                src_step_o = STEP_INC;
                dst_step_o = STEP_INC;
            end
        endcase
    end

endmodule

// File: rtl/bmx_addr_step.sv
module bmx_addr_step
    import bmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  step_e         kind_i,
    input  logic          neg_i,   // next swing step is -1
    output logic [AW-1:0] addr_o,
    output logic          neg_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        addr_o = addr_i;
        neg_o  = 1'b0;
        unique case (kind_i)
            STEP_INC:  addr_o = addr_i + ONE;
            STEP_DEC:  addr_o = addr_i - ONE;
            STEP_HOLD: addr_o = addr_i;
            STEP_SWING: begin
                addr_o = neg_i ? (addr_i - ONE) : (addr_i + ONE);
                neg_o  = ~neg_i;
            end
            default: addr_o = addr_i;
        endcase
    end

endmodule

// File: rtl/bmx_engine.sv
module bmx_engine
    import bmx_pkg::*;
#(
    parameter int AW           = 16,
    parameter int LW           = 16,
    parameter int DW           = 8,
    parameter int SPW          = 8,
    parameter int CYC_PER_BYTE = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2:0]     mode_i,
    input  logic [AW-1:0]  src_i,
    input  logic [AW-1:0]  dst_i,
    input  logic [LW-1:0]  len_i,
    input  logic [SPW-1:0] sp_i,
    input  logic [DW-1:0]  reg_y_i,
    input  logic [DW-1:0]  reg_a_i,
    input  logic [DW-1:0]  reg_x_i,
    output logic           stk_we_o,
    output logic [SPW-1:0] stk_addr_o,
    output logic [DW-1:0]  stk_wdata_o,
    output logic           mem_re_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           busy_o,
    output logic           done_o
);

    localparam int PW      = $clog2(CYC_PER_BYTE);
    localparam int NSIDE   = 2;          // 0: source, 1: destination
    localparam int NPUSH   = 3;
    localparam logic [PW-1:0] CYC_CAP  = PW'(1);
    localparam logic [PW-1:0] CYC_WR   = PW'(CYC_PER_BYTE - 1);
    localparam logic [1:0]    PUSH_END = 2'(NPUSH - 1);

    typedef struct packed {
        phase_e                  ph;
        logic [1:0]              pidx;
        logic [PW-1:0]           cyc;
        logic [LW-1:0]           left;   // bytes remaining minus one
        logic [NSIDE-1:0][AW-1:0] addr;
        logic [NSIDE-1:0]        neg;
        step_e [NSIDE-1:0]       kind;
        logic [DW-1:0]           ry;
        logic [DW-1:0]           ra;
        logic [DW-1:0]           rx;
        logic [DW-1:0]           hold;
        logic [SPW-1:0]          sp;
        logic                    done;
    } state_t;

    state_t q, d;

    step_e               map_src, map_dst;
    logic [AW-1:0]       nxt_addr [NSIDE];
    logic                nxt_neg  [NSIDE];

    bmx_mode_map u_map (
        .mode_i     (mode_i),
        .src_step_o (map_src),
        .dst_step_o (map_dst)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        bmx_addr_step #(.AW(AW)) u_step (
            .addr_i (q.addr[s]),
            .kind_i (q.kind[s]),
            .neg_i  (q.neg[s]),
            .addr_o (nxt_addr[s]),
            .neg_o  (nxt_neg[s])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.ph      = PH_PUSH;
                    d.pidx    = 2'd0;
                    d.cyc     = '0;
                    d.left    = len_i - LW'(1);  // 0 wraps to all ones
                    d.addr[0] = src_i;
                    d.addr[1] = dst_i;
                    d.neg     = '0;
                    d.kind[0] = map_src;
                    d.kind[1] = map_dst;
                    d.ry      = reg_y_i;
                    d.ra      = reg_a_i;
                    d.rx      = reg_x_i;
                    d.sp      = sp_i;
                end
            end
            PH_PUSH: begin
                if (q.pidx == PUSH_END) begin
                    d.ph  = PH_MOVE;
                    d.cyc = '0;
                end else begin
                    d.pidx = q.pidx + 2'd1;
                end
            end
            PH_MOVE: begin
                if (q.cyc == CYC_CAP) begin
                    d.hold = mem_rdata_i;
                end
                if (q.cyc == CYC_WR) begin
                    d.cyc = '0;
                    for (int s = 0; s < NSIDE; s++) begin
                        d.addr[s] = nxt_addr[s];
                        d.neg[s]  = nxt_neg[s];
                    end
                    if (q.left == '0) begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.left = q.left - LW'(1);
                    end
                end else begin
                    d.cyc = q.cyc + PW'(1);
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Output decode
    always_comb begin
        stk_we_o    = (q.ph == PH_PUSH);
        stk_addr_o  = q.sp - SPW'({1'b0, q.pidx} + 3'd1);
        unique case (q.pidx)
            2'd0:    stk_wdata_o = q.ry;
            2'd1:    stk_wdata_o = q.ra;
            default: stk_wdata_o = q.rx;
        endcase
        mem_re_o    = (q.ph == PH_MOVE) && (q.cyc == '0);
        mem_we_o    = (q.ph == PH_MOVE) && (q.cyc == CYC_WR);
        mem_addr_o  = mem_we_o ? q.addr[1] : q.addr[0];
        mem_wdata_o = q.hold;
        busy_o      = (q.ph != PH_IDLE);
        done_o      = q.done;
    end

endmodule

// File: rtl/bmx_engine_checks.sv
module bmx_engine_checks (
    input logic clk,
    input logic rst_n,
    input logic stk_we_o,
    input logic mem_re_o,
    input logic mem_we_o,
    input logic busy_o,
    input logic done_o
);

    // R3: strobes never overlap
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_we_o, mem_re_o, mem_we_o}));

    // R2: the first busy cycle is a stack save
    p_busy_opens_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> stk_we_o);

    // R11: done follows a write
    p_done_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_we_o));

    // R11: done lasts one cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: writes only while busy
    p_write_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R11: busy only falls with a done pulse
    p_busy_fall_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

endmodule

bind bmx_engine bmx_engine_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .stk_we_o (stk_we_o),
    .mem_re_o (mem_re_o),
    .mem_we_o (mem_we_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/test_bmx_engine.sv
module test_bmx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [15:0] src_i = '0, dst_i = '0, len_i = '0;
    logic [7:0]  sp_i = '0;
    logic [7:0]  reg_y_i = 8'hA1, reg_a_i = 8'hB2, reg_x_i = 8'hC3;
    logic        stk_we_o, mem_re_o, mem_we_o, busy_o, done_o;
    logic [7:0]  stk_addr_o, stk_wdata_o, mem_wdata_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_rdata_i = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    bmx_engine i_bmx_engine (.*);

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // memory model: data returned on the edge after a read strobe
    always @(posedge clk) if (mem_re_o) mem_rdata_i <= pat(mem_addr_o);

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]            req;
        logic [2:0]            mode;
        logic [15:0]           src;
        logic [15:0]           dst;
        logic [15:0]           len;
        logic [7:0]            sp;
        logic [0:3][15:0]      es;
        logic [0:3][15:0]      ed;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R4
        '{4'd4, 3'd0, 16'h1000, 16'h2000, 16'd3, 8'h80,
          '{16'h1000, 16'h1001, 16'h1002, 16'h0}, '{16'h2000, 16'h2001, 16'h2002, 16'h0}},
        // R5, stack offsets wrap (R2)
        '{4'd5, 3'd1, 16'h1003, 16'h2005, 16'd3, 8'h01,
          '{16'h1003, 16'h1002, 16'h1001, 16'h0}, '{16'h2005, 16'h2004, 16'h2003, 16'h0}},
        // R6
        '{4'd6, 3'd2, 16'h1010, 16'h3000, 16'd4, 8'h40,
          '{16'h1010, 16'h1011, 16'h1012, 16'h1013}, '{16'h3000, 16'h3000, 16'h3000, 16'h3000}},
        // R7
        '{4'd7, 3'd3, 16'h1020, 16'h3010, 16'd4, 8'h40,
          '{16'h1020, 16'h1021, 16'h1022, 16'h1023}, '{16'h3010, 16'h3011, 16'h3010, 16'h3011}},
        // R8
        '{4'd8, 3'd4, 16'h1030, 16'h3020, 16'd4, 8'h40,
          '{16'h1030, 16'h1031, 16'h1030, 16'h1031}, '{16'h3020, 16'h3021, 16'h3022, 16'h3023}},
        // R9 upward wrap
        '{4'd9, 3'd0, 16'hFFFE, 16'hFFFF, 16'd3, 8'h00,
          '{16'hFFFE, 16'hFFFF, 16'h0000, 16'h0}, '{16'hFFFF, 16'h0000, 16'h0001, 16'h0}},
        // R9 downward wrap
        '{4'd9, 3'd1, 16'h0001, 16'h0000, 16'd3, 8'h10,
          '{16'h0001, 16'h0000, 16'hFFFF, 16'h0}, '{16'h0000, 16'hFFFF, 16'hFFFE, 16'h0}},
        // R13 unused code acts as code 0
        '{4'd13, 3'd6, 16'h1040, 16'h3030, 16'd2, 8'h20,
          '{16'h1040, 16'h1041, 16'h0, 16'h0}, '{16'h3030, 16'h3031, 16'h0, 16'h0}}
    };

    task automatic run_vec(input vec_t v, input bit poke);
        logic [7:0] e_sp;
        @(negedge clk);
        start_i = 1'b1; mode_i = v.mode; src_i = v.src; dst_i = v.dst;
        len_i = v.len; sp_i = v.sp;
        @(negedge clk);                     // cycle 1: first save
        start_i = 1'b0;
        e_sp = v.sp - 8'd1;
        chk(busy_o == 1'b1, 11, "busy after start", busy_o, 1);
        chk(stk_we_o && stk_addr_o == e_sp && stk_wdata_o == reg_y_i, 2, "save Y",
            {stk_we_o, stk_addr_o, stk_wdata_o}, {1'b1, e_sp, reg_y_i});
        if (poke) begin
            start_i = 1'b1; mode_i = 3'd1; src_i = 16'hAAAA; dst_i = 16'h5555; len_i = 16'd9;
        end
        @(negedge clk);                     // cycle 2
        start_i = 1'b0;
        e_sp = v.sp - 8'd2;
        chk(stk_we_o && stk_addr_o == e_sp && stk_wdata_o == reg_a_i, 2, "save A",
            {stk_we_o, stk_addr_o, stk_wdata_o}, {1'b1, e_sp, reg_a_i});
        @(negedge clk);                     // cycle 3
        e_sp = v.sp - 8'd3;
        chk(stk_we_o && stk_addr_o == e_sp && stk_wdata_o == reg_x_i, 2, "save X",
            {stk_we_o, stk_addr_o, stk_wdata_o}, {1'b1, e_sp, reg_x_i});
        for (int b = 0; b < int'(v.len); b++) begin
            @(negedge clk);                 // read cycle
            chk(mem_re_o && mem_addr_o == v.es[b], poke ? 12 : int'(v.req),
                "read address", {mem_re_o, mem_addr_o}, {1'b1, v.es[b]});
            repeat (4) @(negedge clk);
            chk(!mem_re_o && !mem_we_o, 3, "no strobe between read and write",
                {mem_re_o, mem_we_o}, 0);
            @(negedge clk);                 // write cycle
            chk(mem_we_o && mem_addr_o == v.ed[b], poke ? 12 : int'(v.req),
                "write address", {mem_we_o, mem_addr_o}, {1'b1, v.ed[b]});
            chk(mem_wdata_o == pat(v.es[b]), 3, "write data", mem_wdata_o, pat(v.es[b]));
            chk(busy_o, 11, "busy on final write cycles", busy_o, 1);
        end
        @(negedge clk);
        chk(done_o && !busy_o, 11, "done pulse", {done_o, busy_o}, 2'b10);
        @(negedge clk);
        chk(!done_o && !mem_re_o, 11, "done single cycle", {done_o, mem_re_o}, 0);
    endtask

    initial begin
        int wr;
        logic [15:0] last;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_re_o && !mem_we_o && !stk_we_o, 1, "reset state",
            {busy_o, done_o, mem_re_o, mem_we_o, stk_we_o}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R12: start during a transfer must not disturb it
        run_vec(VECS[0], 1'b1);

        // R10: length 0 keeps going past 300 bytes
        @(negedge clk);
        start_i = 1'b1; mode_i = 3'd0; src_i = 16'h4000; dst_i = 16'h5000;
        len_i = 16'd0; sp_i = 8'h90;
        @(negedge clk);
        start_i = 1'b0;
        wr = 0; last = '0;
        repeat (2 + 300 * 6) begin
            @(negedge clk);
            if (mem_we_o) begin wr++; last = mem_addr_o; end
        end
        chk(wr == 300, 10, "writes for length 0", wr, 300);
        chk(last == 16'h5000 + 16'd299, 10, "last write address", last, 16'h5000 + 16'd299);
        chk(busy_o, 10, "still busy with length 0", busy_o, 1);

        // R1: reset in the middle of a transfer
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_re_o && !mem_we_o && !stk_we_o, 1, "mid reset",
            {busy_o, done_o, mem_re_o, mem_we_o, stk_we_o}, 0);
        rst_n = 1'b1;

        // R10: length 1 moves exactly one byte
        run_vec('{4'd10, 3'd0, 16'h6000, 16'h7000, 16'd1, 8'h50,
                  '{16'h6000, 16'h0, 16'h0, 16'h0}, '{16'h7000, 16'h0, 16'h0, 16'h0}}, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule